// File: doc/BRIEF.md
# PATA PIO Strobe Generator

This block runs one programmed-I/O access at a time on a parallel ATA device bus. A host raises a request with a read/write flag, a 3-bit register address, a block select (command block or control block) and, for writes, a 16-bit word. The block then drives the two active-low chip selects, the address lines, the read or write strobe and the data-bus enable in three timed phases: address setup, active strobe, and recovery. When the access is over it pulses an acknowledge, and for reads it returns the word captured from the device.

All phase lengths are clock counts that are computed at elaboration from the clock period parameter and a per-mode nanosecond table. Rounding is always upward. Every access uses the 8-bit register timing of the mode, whether it is a data word or a register. If the nominal recovery of a mode is shorter than a floor of 25 ns, the cycle is lengthened instead of being cut short. The chip select stays active for a fixed hold after the strobe has gone away. A device-ready input can hold the strobe active for longer.

Top module: `pata_pio_strobe`

## Requirements
- R1: While reset is low and right after it is released, both chip selects and both strobes are high (inactive), the data enable is low, and ack and busy are low.
- R2: An access lasts setup, then strobe, then recovery. Each is a whole number of clocks equal to the ns value divided by CLK_PERIOD_NS and rounded up. Setup ns for modes 0..4 is 70, 50, 30, 30, 25. Strobe ns is 290, 290, 290, 80, 70. Cycle ns is 600, 383, 240, 180, 120.
- R3: Recovery ns is the cycle minus setup minus strobe. When that is below 25 ns (mode 2) it becomes 25 ns, so the cycle grows. Mode 4 sits exactly at 25 ns and is not changed.
- R4: The selected chip select goes active in the first clock after the request is accepted, with no setup of its own. It stays active through setup and strobe and for ceil(15/CLK_PERIOD_NS) clocks of recovery.
- R5: A write uses the same setup, strobe, recovery and chip-select window as a read. The write strobe pulses on writes, the read strobe pulses on reads, and the other strobe stays high.
- R6: Block select 0 drives cs0_n low with cs1_n high. Block select 1 drives cs1_n low with cs0_n high. The two are never low together. The address lines carry the request's address while a chip select is active.
- R7: On a read, the word on the device data input is captured on the clock edge that ends the strobe. It is presented on rd_data with ack and holds until the next read captures. Writes leave it unchanged.
- R8: A request is taken only while busy is low. busy stays high for the whole access. ack is high for exactly one clock, after recovery ends. Requests raised while busy are ignored.
- R9: The data enable is high only on writes, from the start of setup to the end of the strobe. While it is high, the data output equals the request's write word.
- R10: The mode code is sampled when the request is accepted. Changing it during an access has no effect on that access. Codes 5 to 7 use mode 4 timing.
- R11: If dev_ready is low when the strobe's count runs out, the strobe stays active until dev_ready is high. Recovery then runs its full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | PIO mode code, sampled at acceptance |
| req | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctl | input | 1 | 1 = control block, 0 = command block |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write word |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Word captured by the last read |
| dev_ready | input | 1 | Device ready; low stretches the strobe |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_addr | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_data_out | output | 16 | Data driven toward the device |
| ata_data_oe | output | 1 | Data output enable |
| ata_data_in | input | 16 | Data returned by the device |

## Verification
The properties assume that dev_ready only matters while the strobe is active. They also assume that the data input is stable at the clock edge that ends a read strobe. The bench meets both by changing dev_ready and the data input only at falling clock edges. The properties also assume that the host never relies on a request made while busy. The bench does raise such a request, but only in the middle of an access, and drops it again before recovery ends, so that it cannot be taken as a second access.

// File: rtl/pata_pio_pkg.sv
`timescale 1ns/1ps
package pata_pio_pkg;

   localparam int NUM_MODES = 5;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_PULSE = 2'd2,
      PH_RECOV = 2'd3
   } phase_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int setup_ns(input int m);
      case (m)
         0: return 70;
         1: return 50;
         2: return 30;
         3: return 30;
         default: return 25;
      endcase
   endfunction

   function automatic int pulse_ns(input int m);
      case (m)
         0, 1, 2: return 290;
         3: return 80;
         default: return 70;
      endcase
   endfunction

   function automatic int cycle_ns(input int m);
      case (m)
         0: return 600;
         1: return 383;
         2: return 240;
         3: return 180;
         default: return 120;
      endcase
   endfunction

   // recovery after the strobe, raised to the floor when the nominal is short
   function automatic int recov_ns(input int m, input int floor_ns);
      int r;
      r = cycle_ns(m) - setup_ns(m) - pulse_ns(m);
      return (r < floor_ns) ? floor_ns : r;
   endfunction

endpackage

// File: rtl/pata_mode_timing.sv
`timescale 1ns/1ps
module pata_mode_timing
   import pata_pio_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 4,
   parameter int MIN_RECOV_NS  = 25,
   parameter int CNT_W         = 8,
   parameter int MODE_W        = 3
) (
   input  logic [MODE_W-1:0] mode_i,
   output logic [CNT_W-1:0]  setup_o,
   output logic [CNT_W-1:0]  pulse_o,
   output logic [CNT_W-1:0]  recov_o
);

   localparam int TBL_N = 2 ** MODE_W;

   logic [CNT_W-1:0] tbl_setup [TBL_N];
   logic [CNT_W-1:0] tbl_pulse [TBL_N];
   logic [CNT_W-1:0] tbl_recov [TBL_N];

   for (genvar m = 0; m < TBL_N; m++) begin : g_mode
      // codes past the last mode reuse the fastest mode
      localparam int MI = (m < NUM_MODES) ? m : NUM_MODES - 1;
      localparam int SC = ceil_div(setup_ns(MI), CLK_PERIOD_NS);
      localparam int PC = ceil_div(pulse_ns(MI), CLK_PERIOD_NS);
      localparam int RC = ceil_div(recov_ns(MI, MIN_RECOV_NS), CLK_PERIOD_NS);

      if (SC >= 2 ** CNT_W || PC >= 2 ** CNT_W || RC >= 2 ** CNT_W) begin : g_wide
         $error("CNT_W too narrow for mode timing");
      end

      assign tbl_setup[m] = CNT_W'(SC);
      assign tbl_pulse[m] = CNT_W'(PC);
      assign tbl_recov[m] = CNT_W'(RC);
   end

   assign setup_o = tbl_setup[mode_i];
   assign pulse_o = tbl_pulse[mode_i];
   assign recov_o = tbl_recov[mode_i];

endmodule

// File: rtl/pata_phase_fsm.sv
`timescale 1ns/1ps
module pata_phase_fsm
   import pata_pio_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int HOLD_CLK = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ready_i,
   input  logic [CNT_W-1:0] setup_i,
   input  logic [CNT_W-1:0] pulse_i,
   input  logic [CNT_W-1:0] recov_i,
   output phase_t           phase_o,
   output logic             cs_on_o,
   output logic             sample_o,
   output logic             done_o
);

   localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_CLK);

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] setup_q;
   logic [CNT_W-1:0] pulse_q;
   logic [CNT_W-1:0] recov_q;
   logic             done_q;
   logic             pulse_spent;

   assign pulse_spent = (cnt_q >= pulse_q - 1'b1);
   assign sample_o    = (phase_q == PH_PULSE) && pulse_spent && ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         setup_q <= '0;
         pulse_q <= '0;
         recov_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_SETUP;
                  cnt_q   <= '0;
                  setup_q <= setup_i;
                  pulse_q <= pulse_i;
                  recov_q <= recov_i;
               end
            end
            PH_SETUP: begin
               if (cnt_q == setup_q - 1'b1) begin
                  phase_q <= PH_PULSE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_PULSE: begin
               if (pulse_spent) begin
                  if (ready_i) begin
                     phase_q <= PH_RECOV;
                     cnt_q   <= '0;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (cnt_q == recov_q - 1'b1) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign phase_o = phase_q;
   assign done_o  = done_q;
   assign cs_on_o = (phase_q == PH_SETUP) || (phase_q == PH_PULSE) ||
                    ((phase_q == PH_RECOV) && (cnt_q < HOLD_C));

endmodule

// File: rtl/pata_bus_drive.sv
`timescale 1ns/1ps
module pata_bus_drive
   import pata_pio_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wr_i,
   input  logic              ctl_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  phase_t            phase_i,
   input  logic              cs_on_i,
   input  logic              sample_i,
   input  logic [DATA_W-1:0] bus_in_i,
   output logic              cs0_n_o,
   output logic              cs1_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              dior_n_o,
   output logic              diow_n_o,
   output logic [DATA_W-1:0] bus_out_o,
   output logic              bus_oe_o,
   output logic [DATA_W-1:0] rd_data_o
);

   logic              wr_q;
   logic              ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         ctl_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rd_q    <= '0;
      end else begin
         if (start_i) begin
            wr_q    <= wr_i;
            ctl_q   <= ctl_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
         end
         if (sample_i && !wr_q) begin
            rd_q <= bus_in_i;
         end
      end
   end

   assign cs0_n_o   = !(cs_on_i && !ctl_q);
   assign cs1_n_o   = !(cs_on_i && ctl_q);
   assign addr_o    = addr_q;
   assign dior_n_o  = !((phase_i == PH_PULSE) && !wr_q);
   assign diow_n_o  = !((phase_i == PH_PULSE) && wr_q);
   assign bus_oe_o  = wr_q && ((phase_i == PH_SETUP) || (phase_i == PH_PULSE));
   assign bus_out_o = wdata_q;
   assign rd_data_o = rd_q;

endmodule

// File: rtl/pata_pio_strobe.sv
`timescale 1ns/1ps
module pata_pio_strobe
   import pata_pio_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 4,
   parameter int MIN_RECOV_NS  = 25,
   parameter int CS_HOLD_NS    = 15,
   parameter int CNT_W         = 8,
   parameter int MODE_W        = 3,
   parameter int DATA_W        = 16,
   parameter int ADDR_W        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              req,
   input  logic              req_write,
   input  logic              req_ctl,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              ack,
   output logic [DATA_W-1:0] rd_data,
   input  logic              dev_ready,
   output logic              ata_cs0_n,
   output logic              ata_cs1_n,
   output logic [ADDR_W-1:0] ata_addr,
   output logic              ata_dior_n,
   output logic              ata_diow_n,
   output logic [DATA_W-1:0] ata_data_out,
   output logic              ata_data_oe,
   input  logic [DATA_W-1:0] ata_data_in
);

   localparam int HOLD_CLK  = ceil_div(CS_HOLD_NS, CLK_PERIOD_NS);
   localparam int FLOOR_CLK = ceil_div(MIN_RECOV_NS, CLK_PERIOD_NS);

   if (CLK_PERIOD_NS < 1) begin : g_bad_clk
      $error("CLK_PERIOD_NS must be positive");
   end
   if (CS_HOLD_NS < 1 || HOLD_CLK >= FLOOR_CLK) begin : g_bad_hold
      $error("chip-select hold must be positive and end inside recovery");
   end
   if (MODE_W < 3) begin : g_bad_mode
      $error("MODE_W must cover modes 0 to 4");
   end

   logic [CNT_W-1:0] setup_c;
   logic [CNT_W-1:0] pulse_c;
   logic [CNT_W-1:0] recov_c;
   phase_t           phase;
   logic             cs_on;
   logic             sample;
   logic             start;

   assign busy  = (phase != PH_IDLE);
   assign start = req && !busy;

   pata_mode_timing #(
      .CLK_PERIOD_NS (CLK_PERIOD_NS),
      .MIN_RECOV_NS  (MIN_RECOV_NS),
      .CNT_W         (CNT_W),
      .MODE_W        (MODE_W)
   ) u_timing (
      .mode_i  (mode_sel),
      .setup_o (setup_c),
      .pulse_o (pulse_c),
      .recov_o (recov_c)
   );

   pata_phase_fsm #(
      .CNT_W    (CNT_W),
      .HOLD_CLK (HOLD_CLK)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .ready_i  (dev_ready),
      .setup_i  (setup_c),
      .pulse_i  (pulse_c),
      .recov_i  (recov_c),
      .phase_o  (phase),
      .cs_on_o  (cs_on),
      .sample_o (sample),
      .done_o   (ack)
   );

   pata_bus_drive #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .wr_i      (req_write),
      .ctl_i     (req_ctl),
      .addr_i    (req_addr),
      .wdata_i   (req_wdata),
      .phase_i   (phase),
      .cs_on_i   (cs_on),
      .sample_i  (sample),
      .bus_in_i  (ata_data_in),
      .cs0_n_o   (ata_cs0_n),
      .cs1_n_o   (ata_cs1_n),
      .addr_o    (ata_addr),
      .dior_n_o  (ata_dior_n),
      .diow_n_o  (ata_diow_n),
      .bus_out_o (ata_data_out),
      .bus_oe_o  (ata_data_oe),
      .rd_data_o (rd_data)
   );

endmodule

// File: rtl/pata_pio_strobe_chk.sv
`timescale 1ns/1ps
module pata_pio_strobe_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              ack,
   input logic              dev_ready,
   input logic              ata_cs0_n,
   input logic              ata_cs1_n,
   input logic              ata_dior_n,
   input logic              ata_diow_n,
   input logic              ata_data_oe,
   input logic [DATA_W-1:0] rd_data
);

   // R6
   cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_cs0_n && !ata_cs1_n));

   // R5
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_dior_n && !ata_diow_n));

   // R4
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));

   // R4
   cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ata_dior_n) || $rose(ata_diow_n)) |-> (!ata_cs0_n || !ata_cs1_n));

   // R9
   oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ata_data_oe |-> (ata_dior_n && (!ata_cs0_n || !ata_cs1_n)));

   // R8
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R8
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !busy);

   // R8
   strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_dior_n || !ata_diow_n || ata_data_oe) |-> busy);

   // R11
   release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ata_dior_n) || $rose(ata_diow_n)) |-> $past(dev_ready));

   // R7
   rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> $rose(ata_dior_n));

endmodule

bind pata_pio_strobe pata_pio_strobe_chk #(.DATA_W(DATA_W)) i_pata_pio_strobe_chk (.*);

// File: tb/test_pata_pio_strobe.sv
`timescale 1ns/1ps
module test_pata_pio_strobe;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic        req = 1'b0;
   logic        req_write = 1'b0;
   logic        req_ctl = 1'b0;
   logic [2:0]  req_addr = 3'd0;
   logic [15:0] req_wdata = 16'h0;
   logic        busy;
   logic        ack;
   logic [15:0] rd_data;
   logic        dev_ready = 1'b1;
   logic        ata_cs0_n;
   logic        ata_cs1_n;
   logic [2:0]  ata_addr;
   logic        ata_dior_n;
   logic        ata_diow_n;
   logic [15:0] ata_data_out;
   logic        ata_data_oe;
   logic [15:0] ata_data_in = 16'h0;

   int checks = 0;
   int failures = 0;
   logic [15:0] last_rd = 16'h0;

   localparam int PERIOD = 4;

   always #2 clk = ~clk;

   pata_pio_strobe i_pata_pio_strobe (.*);

   function automatic int cdiv(input int n);
      return (n + PERIOD - 1) / PERIOD;
   endfunction

   function automatic int exp_setup(input int m);
      int t[5] = '{70, 50, 30, 30, 25};
      return cdiv(t[m]);
   endfunction

   function automatic int exp_pulse(input int m);
      int t[5] = '{290, 290, 290, 80, 70};
      return cdiv(t[m]);
   endfunction

   function automatic int exp_recov(input int m);
      int cyc[5] = '{600, 383, 240, 180, 120};
      int s[5]   = '{70, 50, 30, 30, 25};
      int p[5]   = '{290, 290, 290, 80, 70};
      int r;
      r = cyc[m] - s[m] - p[m];
      if (r < 25) r = 25;
      return cdiv(r);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n, "R1 idle strobes in reset",
          {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n}, 4'hf);
      chk(!ata_data_oe && !ack && !busy, "R1 oe/ack/busy in reset",
          {ata_data_oe, ack, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_data_oe && !busy && !ack,
          "R1 idle after release", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_data_oe, busy, ack},
          7'b1111000);
   endtask

   task automatic run_access(input int code, input bit wr, input bit ctl, input logic [2:0] addr,
                             input logic [15:0] wd, input int stretch, input bit chg_mode,
                             input bit poke_req, input string tag);
      int m;
      int es, ep, er, eh;
      int n_busy, n_cs, n_setup, n_st, n_other, n_oe, bad_cs, bad_addr, bad_data;
      bit seen, done, first_cs;
      m  = (code > 4) ? 4 : code;
      es = exp_setup(m);
      ep = exp_pulse(m);
      er = exp_recov(m);
      eh = cdiv(15);
      n_busy = 0; n_cs = 0; n_setup = 0; n_st = 0; n_other = 0; n_oe = 0;
      bad_cs = 0; bad_addr = 0; bad_data = 0;
      seen = 0; done = 0; first_cs = 0;

      @(negedge clk);
      mode_sel  = 3'(code);
      req       = 1'b1;
      req_write = wr;
      req_ctl   = ctl;
      req_addr  = addr;
      req_wdata = wd;
      dev_ready = (stretch == 0);
      @(negedge clk);
      chk(busy, {"R8 accepted ", tag}, busy, 1);
      req = 1'b0;
      first_cs = ctl ? !ata_cs1_n : !ata_cs0_n;
      chk(first_cs, {"R4 cs in first clock ", tag}, first_cs, 1);

      for (int i = 0; i < 3000 && !done; i++) begin
         if (ack) begin
            done = 1;
         end else begin
            bit sel, wrong, st, oth;
            sel   = ctl ? !ata_cs1_n : !ata_cs0_n;
            wrong = ctl ? !ata_cs0_n : !ata_cs1_n;
            st    = wr ? !ata_diow_n : !ata_dior_n;
            oth   = wr ? !ata_dior_n : !ata_diow_n;
            if (busy) n_busy++;
            if (sel) n_cs++;
            if (wrong) bad_cs++;
            if (sel && ata_addr != addr) bad_addr++;
            if (oth) n_other++;
            if (sel && !seen && !st) n_setup++;
            if (st) begin
               seen = 1;
               n_st++;
               ata_data_in = 16'hA500 + 16'(n_st);
               if (stretch > 0 && n_st == ep + stretch) dev_ready = 1'b1;
            end
            if (ata_data_oe) begin
               n_oe++;
               if (ata_data_out != wd) bad_data++;
            end
            if (chg_mode && i == 0) mode_sel = (m == 0) ? 3'd4 : 3'd0;
            if (poke_req && i == 2) begin req = 1'b1; req_write = !wr; end
            if (poke_req && i == 4) begin req = 1'b0; req_write = wr; end
            @(negedge clk);
         end
      end

      chk(done, {"R8 ack seen ", tag}, done, 1);
      chk(n_busy == es + ep + stretch + er, {"R2 R3 busy length ", tag}, n_busy, es + ep + stretch + er);
      chk(n_setup == es, {"R2 setup length ", tag}, n_setup, es);
      chk(n_st == ep + stretch, {"R2 R11 strobe length ", tag}, n_st, ep + stretch);
      chk(n_cs == es + ep + stretch + eh, {"R4 cs window ", tag}, n_cs, es + ep + stretch + eh);
      chk(bad_cs == 0 && bad_addr == 0, {"R6 cs/addr select ", tag}, bad_cs + bad_addr, 0);
      chk(n_other == 0, {"R5 other strobe idle ", tag}, n_other, 0);
      chk(n_oe == (wr ? es + ep + stretch : 0), {"R9 oe window ", tag}, n_oe, wr ? es + ep + stretch : 0);
      chk(bad_data == 0, {"R9 write word ", tag}, bad_data, 0);
      if (wr) begin
         chk(rd_data == last_rd, {"R7 rd held on write ", tag}, rd_data, last_rd);
      end else begin
         chk(rd_data == 16'hA500 + 16'(ep + stretch), {"R7 rd captured ", tag},
             rd_data, 16'hA500 + 16'(ep + stretch));
         last_rd = rd_data;
      end
      @(negedge clk);
      chk(!ack && !busy, {"R8 single ack ", tag}, {ack, busy}, 0);
      chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_data_oe,
          {"R1 idle bus after ", tag}, {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_data_oe}, 5'b11110);
      dev_ready = 1'b1;
   endtask

   // R2 R7: mode 0 read, command block
   task automatic t_read_mode0;
      run_access(0, 1'b0, 1'b0, 3'd7, 16'h0, 0, 1'b0, 1'b0, "m0 read");
   endtask

   // R5 R6 R9: mode 1 write to control block offset 6
   task automatic t_write_ctl;
      run_access(1, 1'b1, 1'b1, 3'd6, 16'h5A3C, 0, 1'b0, 1'b0, "m1 ctl write");
   endtask

   // R3: mode 2 recovery raised to the floor
   task automatic t_recov_floor;
      run_access(2, 1'b0, 1'b0, 3'd2, 16'h0, 0, 1'b0, 1'b0, "m2 floor read");
   endtask

   // R5: mode 3 write, same timing as a read
   task automatic t_write_m3;
      run_access(3, 1'b1, 1'b0, 3'd0, 16'hC0DE, 0, 1'b0, 1'b0, "m3 write");
      run_access(3, 1'b0, 1'b0, 3'd0, 16'h0, 0, 1'b0, 1'b0, "m3 read");
   endtask

   // R3 R10: mode 4 at the floor, and code 6 mapped to mode 4
   task automatic t_mode4;
      run_access(4, 1'b0, 1'b1, 3'd6, 16'h0, 0, 1'b0, 1'b0, "m4 read");
      run_access(6, 1'b1, 1'b0, 3'd5, 16'h1234, 0, 1'b0, 1'b0, "code6 write");
   endtask

   // R11: dev_ready low stretches the strobe
   task automatic t_stretch;
      run_access(3, 1'b0, 1'b0, 3'd1, 16'h0, 12, 1'b0, 1'b0, "m3 stretch read");
      run_access(4, 1'b1, 1'b1, 3'd6, 16'hBEEF, 5, 1'b0, 1'b0, "m4 stretch write");
   endtask

   // R10: mode input changed during an access
   task automatic t_mode_change;
      run_access(4, 1'b0, 1'b0, 3'd3, 16'h0, 0, 1'b1, 1'b0, "m4 mode change");
      run_access(1, 1'b1, 1'b0, 3'd4, 16'h7777, 0, 1'b1, 1'b0, "m1 mode change");
   endtask

   // R8: request while busy ignored
   task automatic t_busy_ignore;
      run_access(3, 1'b0, 1'b0, 3'd5, 16'h0, 0, 1'b0, 1'b1, "m3 busy poke");
   endtask

   initial begin
      #(200000 * PERIOD);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_read_mode0();
      t_write_ctl();
      t_recov_floor();
      t_write_m3();
      t_mode4();
      t_stretch();
      t_mode_change();
      t_busy_ignore();
      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule